// File: doc/BRIEF.md
# Cross-Pipeline Result Reorder Unit

This unit sits behind a row of parallel lookup table stages that share one rule set. A lookup enters at one pipeline and visits table stages in circular order until it completes. It can therefore finish in a stage that belongs to a different pipeline, after passing through anywhere from one to all of the stages. Each finished entry reaches this unit on the input channel of the stage where it completed. It carries its key, its result value and an 8-bit state word.

The unit counts the visited stages recorded in the state word, which gives the hop count. From the hop count and the arrival channel it derives the pipeline the entry entered from. It places the entry into a delay line that feeds that pipeline's output port. The entry's position in the line tops its latency up to the worst case of visiting every stage. Every entry therefore spends the same number of cycles in the whole structure. Entries of one pipeline leave in the order they entered, and entries admitted together leave together.

Stage latency `STAGE_LAT` and the pipeline count are parameters. With the defaults, four pipelines and four cycles per stage, an entry leaves its origin port exactly 17 cycles after it was admitted to its first stage.

Top module: `reorder_unit`

## Requirements
- R1: While reset is low, every in-flight entry is discarded. On the first cycle after reset and afterwards, no output is valid until a new entry arrives, even when entries were in flight when reset was applied.
- R2: The state word is decoded as follows: bit 0 is the success flag, bits 2:1 the opcode (00 none, 01 insert, 10 delete, 11 query), bits 6:3 a visited map with bit 3+i for pipeline i, and bit 7 the to-CAM flag. A 0 in the visited map means visited. The hop count k is the number of zero bits in the map. A valid entry with a non-empty map has its own arrival channel marked visited.
- R3: An entry arriving on channel c with hop count k leaves on output port (c − k + 1) mod 4.
- R4: An entry arriving with hop count k appears at its output port (4 − k)·STAGE_LAT + 1 clock edges after the edge that samples it. Measured from admission to its first stage, the latency is 4·STAGE_LAT + 1 for every entry.
- R5: Key, value and the full state word leave unchanged. The opcode, success flag and to-CAM flag have no effect on routing or timing.
- R6: Entries admitted in the same cycle leave in the same cycle. Entries of the same pipeline leave in admission order.
- R7: An output port is valid only in the cycle a scheduled entry reaches it.
- R8: Inputs with the valid bit low are ignored whatever their data. A valid entry whose visited map is all ones is dropped.
- R9: When four entries arrive on all four channels in one cycle bound for four distinct ports, each leaves on its own port without disturbing the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inValid | input | NUM_PIPES | Per-channel entry valid |
| inKey | input | NUM_PIPES*KEY_W | Per-channel key, channel c at bits c*KEY_W upward |
| inValue | input | NUM_PIPES*VAL_W | Per-channel result value |
| inState | input | NUM_PIPES*(NUM_PIPES+4) | Per-channel state word |
| outValid | output | NUM_PIPES | Per-port entry valid |
| outKey | output | NUM_PIPES*KEY_W | Per-port key |
| outValue | output | NUM_PIPES*VAL_W | Per-port result value |
| outState | output | NUM_PIPES*(NUM_PIPES+4) | Per-port state word, unchanged |

## Verification
A wrong hop count or origin shows at the ports within the entry's own latency window. The entry either appears on the wrong port, or on the right port a multiple of STAGE_LAT cycles too early or too late. For that reason every port is compared against a computed schedule in every cycle, not only when an output is expected. A delay-line slot that shifts wrongly or keeps a stale valid bit produces a spurious or missing output within at most 4·STAGE_LAT + 1 cycles. A slot that survives reset shows up in the quiet window that follows a reset with entries in flight.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

  // Fixed field widths of the control-to-datapath strobe; they cover any
  // practical pipeline count and delay-line depth.
  localparam int ORIGIN_W = 8;
  localparam int SLOT_W   = 16;

  // Bit position of the visited map inside the state word.
  localparam int VISIT_LSB = 3;

  typedef struct packed {
    logic                write;
    logic [ORIGIN_W-1:0] origin;
    logic [SLOT_W-1:0]   slot;
  } laneStrobe_t;

  // Number of zero bits in the low `width` bits of visitMap (stages visited).
  function automatic int countVisited(input logic [31:0] visitMap, input int width);
    int hits;
    hits = 0;
    for (int b = 0; b < 32; b++) begin
      if (b < width && !visitMap[b]) hits++;
    end
    return hits;
  endfunction

endpackage

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
  import reorder_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int STAGE_LAT = 4,
  parameter int STATE_W   = NUM_PIPES + 4
) (
  input  logic [NUM_PIPES-1:0]         inValid,
  input  logic [NUM_PIPES*STATE_W-1:0] inState,
  output laneStrobe_t [NUM_PIPES-1:0]  strobes
);

  // One decoder per arrival channel: hop count -> origin port and slot.
  for (genvar c = 0; c < NUM_PIPES; c++) begin : g_lane
    logic [31:0] visitMap;
    int          hops;

    always_comb begin
      visitMap = 32'(inState[c*STATE_W + VISIT_LSB +: NUM_PIPES]);
      hops     = countVisited(visitMap, NUM_PIPES);
      strobes[c].write  = inValid[c] && (hops != 0);
      strobes[c].origin = ORIGIN_W'((c + NUM_PIPES + 1 - hops) % NUM_PIPES);
      strobes[c].slot   = SLOT_W'((NUM_PIPES - hops) * STAGE_LAT);
    end
  end

endmodule

// File: rtl/reorder_datapath.sv
module reorder_datapath
  import reorder_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int STAGE_LAT = 4,
  parameter int KEY_W     = 16,
  parameter int VAL_W     = 16,
  parameter int STATE_W   = NUM_PIPES + 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  laneStrobe_t [NUM_PIPES-1:0]  strobes,
  input  logic [NUM_PIPES*KEY_W-1:0]   inKey,
  input  logic [NUM_PIPES*VAL_W-1:0]   inValue,
  input  logic [NUM_PIPES*STATE_W-1:0] inState,
  output logic [NUM_PIPES-1:0]         outValid,
  output logic [NUM_PIPES*KEY_W-1:0]   outKey,
  output logic [NUM_PIPES*VAL_W-1:0]   outValue,
  output logic [NUM_PIPES*STATE_W-1:0] outState
);

  // Slot 0 drives the port; slot i reaches the port after i more edges.
  localparam int DEPTH = (NUM_PIPES - 1) * STAGE_LAT + 1;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_port
    logic [DEPTH-1:0]   slotValid;
    logic [KEY_W-1:0]   slotKey   [DEPTH];
    logic [VAL_W-1:0]   slotValue [DEPTH];
    logic [STATE_W-1:0] slotState [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotValid <= '0;
      end else begin
        slotValid <= {1'b0, slotValid[DEPTH-1:1]};
        for (int i = 0; i < DEPTH - 1; i++) begin
          slotKey[i]   <= slotKey[i+1];
          slotValue[i] <= slotValue[i+1];
          slotState[i] <= slotState[i+1];
        end
        for (int ch = 0; ch < NUM_PIPES; ch++) begin
          for (int i = 0; i < DEPTH; i++) begin
            if (strobes[ch].write && strobes[ch].origin == ORIGIN_W'(p)
                && strobes[ch].slot == SLOT_W'(i)) begin
              slotValid[i] <= 1'b1;
              slotKey[i]   <= inKey[ch*KEY_W +: KEY_W];
              slotValue[i] <= inValue[ch*VAL_W +: VAL_W];
              slotState[i] <= inState[ch*STATE_W +: STATE_W];
            end
          end
        end
      end
    end

    assign outValid[p]                    = slotValid[0];
    assign outKey[p*KEY_W +: KEY_W]       = slotKey[0];
    assign outValue[p*VAL_W +: VAL_W]     = slotValue[0];
    assign outState[p*STATE_W +: STATE_W] = slotState[0];
  end

endmodule

// File: rtl/reorder_unit.sv
module reorder_unit
  import reorder_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int STAGE_LAT = 4,
  parameter int KEY_W     = 16,
  parameter int VAL_W     = 16,
  localparam int STATE_W  = NUM_PIPES + 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PIPES-1:0]         inValid,
  input  logic [NUM_PIPES*KEY_W-1:0]   inKey,
  input  logic [NUM_PIPES*VAL_W-1:0]   inValue,
  input  logic [NUM_PIPES*STATE_W-1:0] inState,
  output logic [NUM_PIPES-1:0]         outValid,
  output logic [NUM_PIPES*KEY_W-1:0]   outKey,
  output logic [NUM_PIPES*VAL_W-1:0]   outValue,
  output logic [NUM_PIPES*STATE_W-1:0] outState
);

  laneStrobe_t [NUM_PIPES-1:0] laneStrobes;

  reorder_ctrl #(
    .NUM_PIPES(NUM_PIPES), .STAGE_LAT(STAGE_LAT), .STATE_W(STATE_W)
  ) ctrl_i (
    .inValid(inValid), .inState(inState), .strobes(laneStrobes)
  );

  reorder_datapath #(
    .NUM_PIPES(NUM_PIPES), .STAGE_LAT(STAGE_LAT),
    .KEY_W(KEY_W), .VAL_W(VAL_W), .STATE_W(STATE_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(laneStrobes),
    .inKey(inKey), .inValue(inValue), .inState(inState),
    .outValid(outValid), .outKey(outKey), .outValue(outValue), .outState(outState)
  );

endmodule

// File: rtl/reorder_unit_chk.sv
module reorder_unit_chk
  import reorder_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int STAGE_LAT = 4,
  parameter int KEY_W     = 16,
  parameter int VAL_W     = 16,
  parameter int STATE_W   = NUM_PIPES + 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_PIPES-1:0]         inValid,
  input logic [NUM_PIPES*KEY_W-1:0]   inKey,
  input logic [NUM_PIPES*STATE_W-1:0] inState,
  input logic [NUM_PIPES-1:0]         outValid,
  input logic [NUM_PIPES*KEY_W-1:0]   outKey,
  input logic [NUM_PIPES*STATE_W-1:0] outState,
  input laneStrobe_t [NUM_PIPES-1:0]  strobes
);

  assert_idle_after_reset_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (outValid == '0));

  for (genvar c = 0; c < NUM_PIPES; c++) begin : g_lane
    localparam int DST = (c + 1) % NUM_PIPES;

    // An entry that visited something must have visited its arrival stage.
    assert_arrival_visited_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      (inValid[c] && inState[c*STATE_W + VISIT_LSB +: NUM_PIPES] != '1)
        |-> !inState[c*STATE_W + VISIT_LSB + c]);

    // Full-traversal entries need no padding: out one edge later, next port.
    assert_full_path_latency_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (inValid[c] && inState[c*STATE_W + VISIT_LSB +: NUM_PIPES] == '0)
        |=> (outValid[DST]
             && outKey[DST*KEY_W +: KEY_W] == $past(inKey[c*KEY_W +: KEY_W])
             && outState[DST*STATE_W +: STATE_W] == $past(inState[c*STATE_W +: STATE_W])));

    for (genvar d = c + 1; d < NUM_PIPES; d++) begin : g_pair
      assert_unique_slot_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(strobes[c].write && strobes[d].write
          && strobes[c].origin == strobes[d].origin
          && strobes[c].slot == strobes[d].slot));
    end
  end

endmodule

bind reorder_unit reorder_unit_chk #(
  .NUM_PIPES(NUM_PIPES), .STAGE_LAT(STAGE_LAT),
  .KEY_W(KEY_W), .VAL_W(VAL_W), .STATE_W(STATE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inKey(inKey), .inState(inState),
  .outValid(outValid), .outKey(outKey), .outState(outState), .strobes(laneStrobes)
);

// File: tb/reorder_unit_test.sv
module reorder_unit_test;

  localparam int NP   = 4;
  localparam int L    = 4;
  localparam int KW   = 16;
  localparam int VW   = 16;
  localparam int SW   = NP + 4;
  localparam int NC   = 230;
  localparam int RSTC = 206;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    inValid = '0;
  logic [NP*KW-1:0] inKey = '0;
  logic [NP*VW-1:0] inValue = '0;
  logic [NP*SW-1:0] inState = '0;
  logic [NP-1:0]    outValid;
  logic [NP*KW-1:0] outKey;
  logic [NP*VW-1:0] outValue;
  logic [NP*SW-1:0] outState;

  always #10 clk = ~clk;

  reorder_unit #(.NUM_PIPES(NP), .STAGE_LAT(L), .KEY_W(KW), .VAL_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inKey(inKey), .inValue(inValue),
    .inState(inState), .outValid(outValid), .outKey(outKey), .outValue(outValue),
    .outState(outState)
  );

  // Stimulus by cycle and channel; expectations by cycle and port.
  bit          arrV   [NC][NP];
  logic [15:0] arrKey [NC][NP];
  logic [15:0] arrVal [NC][NP];
  logic [7:0]  arrSt  [NC][NP];
  bit          expV   [NC][NP];
  logic [15:0] expKey [NC][NP];
  logic [15:0] expVal [NC][NP];
  logic [7:0]  expSt  [NC][NP];
  int          expHop [NC][NP];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Visited map: bits p .. p+k-1 (mod NP) cleared, 0 = visited (R2).
  function automatic logic [3:0] visitMap(input int p, input int k);
    logic [3:0] v;
    v = 4'b1111;
    for (int i = 0; i < k; i++) v[(p + i) % NP] = 1'b0;
    return v;
  endfunction

  initial begin
    // Junk data everywhere; only valid arrivals matter (R8).
    for (int m = 0; m < NC; m++) begin
      for (int c = 0; c < NP; c++) begin
        arrV[m][c] = 1'b0;
        arrKey[m][c] = 16'(m * 97 + c * 13 + 7);
        arrVal[m][c] = 16'(m * 31 + c);
        arrSt[m][c] = 8'(m * 11 + c * 3);
        expV[m][c] = 1'b0;
        expKey[m][c] = '0; expVal[m][c] = '0; expSt[m][c] = '0; expHop[m][c] = 0;
      end
    end
    // Entry schedule: pipeline p admits an entry at time t that finishes after k stages.
    for (int t = 0; t < NC; t++) begin
      if ((t >= 24 && t < 40) || (t >= 100 && t < 150) || (t >= 185 && t < 200) || t >= 202)
        continue;
      for (int p = 0; p < NP; p++) begin
        int k;
        int kk;
        int a;
        int ch;
        int ex;
        kk = (t * 7 + p * 3 + t / 5) % 6;
        k = (kk == 5) ? 4 : kk;
        if (t == 40) k = 4;
        if (t == 41 || t >= 200) k = 1;
        if (t == 42) k = p + 1;
        if (k == 0) continue;
        a = t + k * L;
        ch = (p + k - 1) % NP;
        if (a >= NC || arrV[a][ch]) continue;
        arrV[a][ch] = 1'b1;
        arrKey[a][ch] = 16'(t * 4 + p + 16'h100);
        arrVal[a][ch] = 16'((t * 4 + p) * 3) ^ 16'h5a5a;
        arrSt[a][ch] = {1'(p ^ t), visitMap(p, k), 2'((t + p) % 4), 1'(t % 2)};
        ex = t + NP * L + 1;   // R4: fixed total latency
        if (t < 200) begin
          expV[ex][p] = 1'b1;
          expKey[ex][p] = arrKey[a][ch];
          expVal[ex][p] = arrVal[a][ch];
          expSt[ex][p] = arrSt[a][ch];
          expHop[ex][p] = k;
        end
      end
    end
    // R8 window: valid entries with nothing visited must be dropped.
    for (int m = 120; m <= 140; m += 5) begin
      for (int c = 0; c < NP; c++) begin
        arrV[m][c] = 1'b1;
        arrSt[m][c] = {1'b1, 4'b1111, 2'b11, 1'b1};
      end
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < NC; m++) begin
      int nExp;
      int nGot;
      cyc = m;
      nExp = 0;
      nGot = 0;
      for (int p = 0; p < NP; p++) begin
        if (expV[m][p]) begin
          string tag;
          nExp++;
          tag = (expHop[m][p] == 1) ? "R2" : (expHop[m][p] == 4) ? "R4" : "R3";
          check(outValid[p] === 1'b1, tag, 32'(outValid[p]), 32'd1);
          check(outKey[p*KW +: KW] === expKey[m][p], "R5 key",
                32'(outKey[p*KW +: KW]), 32'(expKey[m][p]));
          check(outValue[p*VW +: VW] === expVal[m][p], "R5 value",
                32'(outValue[p*VW +: VW]), 32'(expVal[m][p]));
          check(outState[p*SW +: SW] === expSt[m][p], "R5 state",
                32'(outState[p*SW +: SW]), 32'(expSt[m][p]));
        end else begin
          string tag;
          tag = (m == 0 || m > RSTC) ? "R1" : (m >= 120 && m <= 165) ? "R8" : "R7";
          check(outValid[p] === 1'b0, tag, 32'(outValid[p]), 32'd0);
        end
        if (outValid[p] === 1'b1) nGot++;
      end
      if (nExp >= 2) begin
        check(nGot == nExp, (nExp == NP) ? "R9" : "R6", 32'(nGot), 32'(nExp));
      end
      if (m == RSTC) rst_n = 1'b0;
      if (m == RSTC + 2) rst_n = 1'b1;
      for (int c = 0; c < NP; c++) begin
        inValid[c] = (m < RSTC) ? arrV[m][c] : 1'b0;
        inKey[c*KW +: KW] = arrKey[m][c];
        inValue[c*VW +: VW] = arrVal[m][c];
        inState[c*SW +: SW] = arrSt[m][c];
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (NC + 200) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule